// File: doc/BRIEF.md
# Aperture page remapping table

This block remaps a fixed window of input addresses onto physical memory, one 4 KiB page at a time. It keeps one entry per page of the window. Each entry holds a valid flag and a page-aligned physical address. A client drives an input address on the lookup port. In the same cycle it gets back either the remapped physical address or a fault flag.

Software fills the table through three word registers at byte offsets inside the block. A control register turns translation on and off. An entry selector register takes a full byte address inside the window, not a table index. An entry data register writes the selected entry or reads it back. To map a page, software writes the selector and then writes the data register. To unmap a page, it writes zero to the data register. The window base and the number of pages are elaboration parameters.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, the control register reads 0, every entry reads 0 and every lookup faults.
- R2: The control register sits at offset 0x0. A write sets the enable from bit 0 of the write data. A read returns the enable in bit 0 and zero in all other bits.
- R3: The entry selector sits at offset 0x4. It stores the full 32-bit write value and reads it back unchanged.
- R4: A write to the entry data register at offset 0x8 stores into entry (selector - base) >> 12. Bit 31 is the valid flag, bits 30:12 are the physical page and bits 11:0 are discarded.
- R5: A read of the entry data register returns the selected entry with bits 11:0 zero. It returns 0 when the selector lies outside the window. Reads at any other offset return 0.
- R6: A data write is ignored when the selector lies outside the window. No entry changes.
- R7: A lookup hits when translation is enabled, the address is inside the window and the entry is valid. On a hit, lk_fault is 0 and lk_phys is {0, entry bits 30:12, lk_addr[11:0]}. The result is combinational, in the same cycle as the address.
- R8: A lookup outside the window, to an invalid entry, or while translation is disabled asserts lk_fault and returns lk_phys = 0.
- R9: The window is inclusive from base to base + pages*4096 - 1. Both base - 1 and base + pages*4096 fall outside it.
- R10: Writing an all-zero value to an entry removes its mapping. Later lookups to that page fault.
- R11: A register write takes effect at the clock edge that samples it. Lookups and reads see it from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset (0x0 control, 0x4 selector, 0x8 entry data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| lk_addr | input | 32 | Lookup input address |
| lk_phys | output | 32 | Remapped physical address, 0 on fault |
| lk_fault | output | 1 | Lookup fault |

## Verification
The assertions assume the register port changes only between clock edges and that the strobe is sampled with a stable offset. They also assume the lookup address is a plain 32-bit value with no qualifying strobe, so every cycle counts as a lookup. The bench drives all inputs just after the falling edge and holds them through the rising edge, so every cycle gives a defined lookup. The address sequences include the first and last page of the window, the addresses one byte outside each bound, and selector values outside the window. Together they reach the out-of-window write path and the index range check.

// File: rtl/aprt_pkg.sv
package aprt_pkg;
   localparam int PAGE_SHIFT = 12;
   localparam int PAGE_BYTES = 1 << PAGE_SHIFT;
   localparam int PHYS_PAGE_W = 31 - PAGE_SHIFT;
   localparam logic [3:0] OFF_CTRL = 4'h0;
   localparam logic [3:0] OFF_SEL  = 4'h4;
   localparam logic [3:0] OFF_DATA = 4'h8;

   typedef struct packed {
      logic                   valid;
      logic [PHYS_PAGE_W-1:0] page;
   } aprt_entry_t;

   localparam int ENT_W = $bits(aprt_entry_t);
endpackage

// File: rtl/aprt_window_decode.sv
module aprt_window_decode #(
   parameter logic [31:0] BASE  = 32'h5800_0000,
   parameter int          PAGES = 32,
   parameter int          IDX_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      addr,
   output logic             in_win,
   output logic [IDX_W-1:0] idx
);
   import aprt_pkg::*;
   localparam logic [32:0] SPAN = 33'(PAGES) << PAGE_SHIFT;

   logic [32:0] off;

   always_comb begin
      off    = {1'b0, addr} - {1'b0, BASE};
      in_win = !off[32] && (off < SPAN);
      idx    = off[IDX_W+PAGE_SHIFT-1:PAGE_SHIFT];
   end

   a_r9_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> (32'(idx) < 32'(PAGES)));
endmodule

// File: rtl/aprt_entry_table.sv
module aprt_entry_table #(
   parameter int PAGES = 32,
   parameter int IDX_W = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [IDX_W-1:0]      widx,
   input  aprt_pkg::aprt_entry_t wval,
   input  logic [IDX_W-1:0]      ridx_a,
   output aprt_pkg::aprt_entry_t rval_a,
   input  logic [IDX_W-1:0]      ridx_b,
   output aprt_pkg::aprt_entry_t rval_b
);
   import aprt_pkg::*;

   aprt_entry_t ents [PAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGES; i++) ents[i] <= '0;
      end else if (we) begin
         ents[widx] <= wval;
      end
   end

   generate
      if ((1 << IDX_W) == PAGES) begin : g_pow2
         always_comb begin
            rval_a = ents[ridx_a];
            rval_b = ents[ridx_b];
         end
      end else begin : g_guarded
         always_comb begin
            rval_a = (32'(ridx_a) < 32'(PAGES)) ? ents[ridx_a] : '0;
            rval_b = (32'(ridx_b) < 32'(PAGES)) ? ents[ridx_b] : '0;
         end
      end
   endgenerate

   a_r6_write_index_legal: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (32'(widx) < 32'(PAGES)));

   a_r4_entry_stored: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (ents[$past(widx)] == $past(wval)));
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap #(
   parameter logic [31:0] BASE  = 32'h5800_0000,
   parameter int          PAGES = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic [31:0] lk_addr,
   output logic [31:0] lk_phys,
   output logic        lk_fault
);
   import aprt_pkg::*;
   localparam int          IDX_W = (PAGES > 1) ? $clog2(PAGES) : 1;
   localparam logic [32:0] WIN_END = {1'b0, BASE} + (33'(PAGES) << PAGE_SHIFT);

   generate
      if (BASE[PAGE_SHIFT-1:0] != '0) begin : g_bad_base
         $error("BASE must be page aligned");
      end
      if (PAGES < 1) begin : g_bad_pages
         $error("PAGES must be at least 1");
      end
      if (WIN_END > 33'h1_0000_0000) begin : g_bad_span
         $error("window exceeds 32-bit address space");
      end
   endgenerate

   logic        en_q;
   logic [31:0] sel_q;
   logic             sel_in, lk_in;
   logic [IDX_W-1:0] sel_idx, lk_idx;
   aprt_entry_t      sel_ent, lk_ent, wr_ent;
   logic             tab_we, hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == OFF_CTRL) en_q  <= reg_wdata[0];
         if (reg_addr == OFF_SEL)  sel_q <= reg_wdata;
      end
   end

   aprt_window_decode #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_sel_dec (
      .clk(clk), .rst_n(rst_n), .addr(sel_q), .in_win(sel_in), .idx(sel_idx));

   aprt_window_decode #(.BASE(BASE), .PAGES(PAGES), .IDX_W(IDX_W)) u_lk_dec (
      .clk(clk), .rst_n(rst_n), .addr(lk_addr), .in_win(lk_in), .idx(lk_idx));

   always_comb begin
      tab_we       = reg_wr && (reg_addr == OFF_DATA) && sel_in;
      wr_ent.valid = reg_wdata[31];
      wr_ent.page  = reg_wdata[30:PAGE_SHIFT];
   end

   aprt_entry_table #(.PAGES(PAGES), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n),
      .we(tab_we), .widx(sel_idx), .wval(wr_ent),
      .ridx_a(sel_idx), .rval_a(sel_ent),
      .ridx_b(lk_idx), .rval_b(lk_ent));

   always_comb begin
      unique case (reg_addr)
         OFF_CTRL: reg_rdata = {31'b0, en_q};
         OFF_SEL:  reg_rdata = sel_q;
         OFF_DATA: reg_rdata = sel_in ? {sel_ent, {PAGE_SHIFT{1'b0}}} : '0;
         default:  reg_rdata = '0;
      endcase
   end

   always_comb begin
      hit      = en_q && lk_in && lk_ent.valid;
      lk_fault = !hit;
      lk_phys  = hit ? {1'b0, lk_ent.page, lk_addr[PAGE_SHIFT-1:0]} : '0;
   end

   a_r8_fault_zero_phys: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault |-> (lk_phys == '0));

   a_r7_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_fault |-> (lk_phys[PAGE_SHIFT-1:0] == lk_addr[PAGE_SHIFT-1:0] && !lk_phys[31]));

   a_r9_hit_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_fault |-> ({1'b0, lk_addr} >= {1'b0, BASE} && {1'b0, lk_addr} < WIN_END));

   a_r2_disable_faults_next: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFF_CTRL && !reg_wdata[0]) |=> lk_fault);

   a_r11_ctrl_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFF_CTRL) |=> (reg_addr != OFF_CTRL || reg_rdata[0] == $past(reg_wdata[0])));
endmodule

// File: tb/tb_aperture_remap.sv
module tb_aperture_remap;
   localparam logic [31:0] BASE  = 32'h5800_0000;
   localparam int          PAGES = 32;
   localparam longint      SPAN  = longint'(PAGES) * 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] lk_addr = '0;
   logic [31:0] lk_phys;
   logic        lk_fault;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   bit          m_en;
   logic [31:0] m_sel;
   logic [31:0] m_tab [PAGES];

   always #5 clk = ~clk;

   aperture_remap #(.BASE(BASE), .PAGES(PAGES)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
      .lk_phys(lk_phys), .lk_fault(lk_fault));

   function automatic bit in_win(input logic [31:0] a);
      return (longint'(a) >= longint'(BASE)) && (longint'(a) - longint'(BASE) < SPAN);
   endfunction

   function automatic int idx_of(input logic [31:0] a);
      return int'((longint'(a) - longint'(BASE)) >> 12);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [3:0] a);
      case (a)
         4'h0: return {31'b0, m_en};
         4'h4: return m_sel;
         4'h8: return in_win(m_sel) ? m_tab[idx_of(m_sel)] : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_en  = 1'b0;
      m_sel = '0;
      for (int i = 0; i < PAGES; i++) m_tab[i] = '0;
   endtask

   task automatic cyc(input bit wr, input logic [3:0] a, input logic [31:0] d,
                      input logic [31:0] lk, input string tag);
      logic [31:0] ep;
      bit          eh;
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; lk_addr = lk;
      #1;
      eh = m_en && in_win(lk) && m_tab[idx_of(lk)][31];
      ep = eh ? ((m_tab[idx_of(lk)] & 32'h7FFF_F000) | {20'h0, lk[11:0]}) : 32'h0;
      check({tag, " rdata"}, reg_rdata, exp_rd(a));
      check({tag, " fault"}, {31'b0, lk_fault}, {31'b0, !eh});
      check({tag, " phys"}, lk_phys, ep);
      @(posedge clk);
      if (rst_n && wr) begin
         if (a == 4'h0) m_en = d[0];
         else if (a == 4'h4) m_sel = d;
         else if (a == 4'h8 && in_win(m_sel)) m_tab[idx_of(m_sel)] = d & 32'hFFFF_F000;
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1 reset state
      cyc(0, 4'h0, 0, BASE, "R1");
      cyc(1, 4'h4, BASE + 32'h3000, BASE + 32'h3004, "R1");
      cyc(0, 4'h8, 0, BASE + 32'h3004, "R1");
      // R3 selector readback
      cyc(0, 4'h4, 0, 0, "R3");
      // R4 write with low bits discarded, R5 readback
      cyc(1, 4'h8, 32'h8123_4FFF, 0, "R4");
      cyc(0, 4'h8, 0, BASE + 32'h3ABC, "R5");
      // R2 enable, R7 hit, R11 next-cycle effect
      cyc(1, 4'h0, 32'hFFFF_FFF1, BASE + 32'h3ABC, "R11");
      cyc(0, 4'h0, 0, BASE + 32'h3ABC, "R7");
      // R9 bounds: first and last page
      cyc(1, 4'h4, BASE, BASE, "R9");
      cyc(1, 4'h8, 32'h8000_5000, BASE, "R9");
      cyc(1, 4'h4, BASE + 32'h1F000, BASE, "R9");
      cyc(1, 4'h8, 32'h8765_4000, BASE + 32'h1FFFF, "R9");
      cyc(0, 4'h8, 0, BASE + 32'h1FFFF, "R9");
      cyc(0, 4'h8, 0, BASE + 32'h20000, "R9");
      cyc(0, 4'h8, 0, BASE - 1, "R9");
      // R6 out-of-window selector write ignored
      cyc(1, 4'h4, BASE - 32'h1000, BASE - 32'h1000, "R6");
      cyc(1, 4'h8, 32'hFFFF_F000, BASE + 32'h1F000, "R6");
      cyc(0, 4'h8, 0, BASE + 32'h1F000, "R5");
      cyc(1, 4'h4, BASE + 32'h20000, BASE, "R6");
      cyc(1, 4'h8, 32'h8000_0000, BASE, "R6");
      cyc(0, 4'hC, 0, BASE + 32'h0FFF, "R5");
      // R8 invalid entry, R10 clearing
      cyc(0, 4'h0, 0, BASE + 32'h2000, "R8");
      cyc(1, 4'h4, BASE + 32'h3000, BASE + 32'h3000, "R10");
      cyc(1, 4'h8, 32'h0, BASE + 32'h3000, "R10");
      cyc(0, 4'h8, 0, BASE + 32'h3000, "R10");
      // R2 disable then re-enable
      cyc(1, 4'h0, 32'h0, BASE, "R2");
      cyc(0, 4'h0, 0, BASE + 32'h1F123, "R2");
      cyc(1, 4'h0, 32'h1, BASE, "R2");
      // mixed traffic against the model, R7 and R8
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r, lk, d;
         logic [3:0]  a;
         r  = $urandom;
         lk = BASE - 32'h800 + ($urandom % 32'h21000);
         d  = $urandom;
         case (r[1:0])
            2'd0: a = 4'h4;
            2'd1: a = 4'h8;
            2'd2: a = (r[5:2] == 0) ? 4'h0 : 4'h8;
            default: a = 4'hC;
         endcase
         if (a == 4'h4) d = BASE - 32'h2000 + ($urandom % 32'h24000);
         if (a == 4'h0) d = {31'b0, r[6] | r[7]};
         cyc(r[8] | r[9], a, d, lk, "R7");
      end
      // R1 reset again mid-run
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); model_reset();
      @(negedge clk); rst_n = 1'b1;
      cyc(0, 4'h0, 0, BASE + 32'h1F000, "R1");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule